// File: doc/BRIEF.md
# SMBus Target Protocol Engine with Byte Memory

This block is the target side of an SMBus link, working one level above the wires. The host side hands it transaction events, one per clock: a start with the write direction, a start with the read direction, a byte written by the host, a byte requested by the host, a not-acknowledge and a stop. Every start carries a 7-bit target address. The engine responds only when that address equals its own `dev_addr` input. Once it has been selected, it follows the event order through a small state machine. When a stop or a repeated start arrives, it works out from the number of bytes collected which transfer took place: a quick command, a send byte, a receive byte, a block write or a command-addressed read.

Behind the protocol engine is a 256-byte register array with an 8-bit offset pointer. A send byte loads the pointer. A receive byte reads at the pointer and then advances it. A block write stores its bytes starting at the command byte and wraps past the top of the array, and it does not move the pointer. A command-addressed read starts at the command on its first byte and then reads sequentially, with no length byte. Any event that breaks the legal order sends the engine into an error state. The error state holds until the next stop.

Top module: `smb_eeprom_target`

## Requirements
- R1: A start event is delivered only when `ev_addr` equals `dev_addr`, and `addr_ack` pulses for one cycle in the cycle after such a start. A start with any other address deselects the engine. While the engine is deselected, all events are ignored and no `rd_valid` pulse appears.
- R2: A write-start (`ev_kind`=0) in the idle state enters the write-collect state. A write-start in any other state raises `confused`. A read-start (`ev_kind`=1) in the idle state enters the single-read state.
- R3: On a stop (`ev_kind`=5) after a write-start, the engine classifies the transfer by its byte count and reports it with one `act_valid` pulse in the next cycle. A count of 0 gives `act_kind`=0 (quick write). A count of 1 gives `act_kind`=2 and loads the pointer with the byte. A count of 2 or more gives `act_kind`=3 and stores bytes 1 onward at the address given by byte 0, leaving the pointer unchanged.
- R4: A block write that runs past address 255 continues at address 0.
- R5: A byte read (`ev_kind`=3) in the single-read state returns the memory byte at the pointer on `rd_data`, with `rd_valid` in the next cycle. The pointer then advances by one, modulo 256. A stop that follows a read-start with no byte read gives `act_kind`=1 (quick read).
- R6: A read-start after exactly one written byte latches that byte as the command (`act_kind`=4). The first byte read returns the memory byte at the command. Each later read returns the next address, wrapping modulo 256, and the pointer follows the last byte read.
- R7: A read-start after two or more written bytes first performs the block write (`act_kind`=3). The reads that follow then return the newly written data.
- R8: A not-acknowledge (`ev_kind`=4) during a command-addressed read ends the read. A second not-acknowledge at that point is ignored. A not-acknowledge in the idle, write-collect or single-read state raises `confused`.
- R9: A byte read in a state that cannot supply data raises `confused` and returns `rd_data`=0x00.
- R10: A read-start after a write-start with no byte written raises `confused`.
- R11: The write buffer holds 33 bytes (the command plus 32 data bytes). Bytes beyond that are dropped and raise `overflow`. A stop clears `overflow`.
- R12: Every stop returns the engine to idle, clears `confused` and discards the byte count.
- R13: A written byte outside the write-collect state has no effect, and neither do `ev_kind` codes 6 and 7. Neither raises `confused` or changes the byte count.
- R14: After reset, the memory is all zero, the pointer is 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_addr | input | 7 | Address this target answers to |
| ev_valid | input | 1 | An event is present this cycle |
| ev_kind | input | 3 | Event code: 0 write-start, 1 read-start, 2 byte written, 3 byte read, 4 not-acknowledge, 5 stop |
| ev_addr | input | 7 | Target address carried by start events |
| ev_wdata | input | 8 | Byte carried by a written-byte event |
| addr_ack | output | 1 | One-cycle pulse after a start that matches `dev_addr` |
| rd_valid | output | 1 | One-cycle pulse carrying a byte for a read event |
| rd_data | output | 8 | Byte returned for a read event |
| act_valid | output | 1 | One-cycle pulse reporting a classified transfer |
| act_kind | output | 3 | Transfer class: 0 quick write, 1 quick read, 2 send byte, 3 block write, 4 command latch |
| confused | output | 1 | Engine is in its error state |
| overflow | output | 1 | Write buffer dropped a byte in this transfer |

## Verification
The bench builds the block with its default parameters: an 8-bit memory address (256 bytes) and a 33-byte write buffer. With these values, a full 32-byte write starting at 0xF0 crosses the top of the array. A 34-data-byte write runs into the buffer limit, so the dropped byte can be seen as an untouched memory location. Sequential reads that start near 0xFE show the read wrap in the same run.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  localparam logic [2:0] EV_START_WR = 3'd0;
  localparam logic [2:0] EV_START_RD = 3'd1;
  localparam logic [2:0] EV_WRITE    = 3'd2;
  localparam logic [2:0] EV_READ     = 3'd3;
  localparam logic [2:0] EV_NACK     = 3'd4;
  localparam logic [2:0] EV_STOP     = 3'd5;

  localparam logic [2:0] ACT_QUICK_W = 3'd0;
  localparam logic [2:0] ACT_QUICK_R = 3'd1;
  localparam logic [2:0] ACT_SEND    = 3'd2;
  localparam logic [2:0] ACT_BLOCK_W = 3'd3;
  localparam logic [2:0] ACT_CMD     = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WCOL  = 3'd1,
    ST_RSING = 3'd2,
    ST_RCMD  = 3'd3,
    ST_DONE  = 3'd4,
    ST_CONF  = 3'd5
  } st_e;

  // True when a cell at distance off past the base lies inside an n-byte run.
  function automatic logic in_window(input int unsigned off, input int unsigned n);
    return off < n;
  endfunction

  function automatic logic is_start(input logic [2:0] k);
    return (k == EV_START_WR) || (k == EV_START_RD);
  endfunction

endpackage

// File: rtl/smbt_sel.sv
module smbt_sel
  import smbt_pkg::*;
#(
  parameter int TA_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TA_W-1:0] dev_addr,
  input  logic            ev_valid,
  input  logic [2:0]      ev_kind,
  input  logic [TA_W-1:0] ev_addr,
  output logic            dlv,
  output logic            sel_q,
  output logic            ack_q
);

  logic hit;
  logic strt;

  assign hit  = (ev_addr == dev_addr);
  assign strt = is_start(ev_kind);
  assign dlv  = ev_valid && (strt ? hit : sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= ev_valid && strt && hit;
      if (ev_valid && strt)
        sel_q <= hit;
      else if (dlv && ev_kind == EV_STOP)
        sel_q <= 1'b0;
    end
  end

endmodule

// File: rtl/smbt_fsm.sv
module smbt_fsm
  import smbt_pkg::*;
#(
  parameter int BUF_BYTES = 33,
  parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        dlv,
  input  logic [2:0]                  kind,
  input  logic [7:0]                  wdata,
  output st_e                         state_o,
  output logic [LEN_W-1:0]            len_o,
  output logic [BUF_BYTES-1:0][7:0]   buf_o,
  output logic [7:0]                  cmd_o,
  output logic                        commit,
  output logic [LEN_W-1:0]            commit_n,
  output logic                        setptr,
  output logic                        rd_req,
  output logic                        rd_use_cmd,
  output logic                        rd_bad,
  output logic                        act_valid_q,
  output logic [2:0]                  act_kind_q,
  output logic                        ovf_q
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(BUF_BYTES);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  st_e                      st_q, st_n;
  logic [LEN_W-1:0]         len_q, len_n;
  logic [BUF_BYTES-1:0][7:0] buf_q;
  logic [7:0]               cmd_q, cmd_n;
  logic                     started_q, started_n;
  logic                     ovf_n;
  logic                     wr_en;
  logic                     act_v;
  logic [2:0]               act_k;

  always_comb begin
    st_n       = st_q;
    len_n      = len_q;
    cmd_n      = cmd_q;
    started_n  = started_q;
    ovf_n      = ovf_q;
    wr_en      = 1'b0;
    commit     = 1'b0;
    setptr     = 1'b0;
    rd_req     = 1'b0;
    rd_use_cmd = 1'b0;
    rd_bad     = 1'b0;
    act_v      = 1'b0;
    act_k      = ACT_QUICK_W;
    if (dlv) begin
      case (kind)
        EV_START_WR: st_n = (st_q == ST_IDLE) ? ST_WCOL : ST_CONF;
        EV_START_RD: begin
          case (st_q)
            ST_IDLE: st_n = ST_RSING;
            ST_WCOL: begin
              if (len_q == '0) begin
                st_n = ST_CONF;
              end else begin
                cmd_n     = buf_q[0];
                started_n = 1'b0;
                len_n     = '0;
                st_n      = ST_RCMD;
                act_v     = 1'b1;
                if (len_q == LEN_ONE) begin
                  act_k = ACT_CMD;
                end else begin
                  act_k  = ACT_BLOCK_W;
                  commit = 1'b1;
                end
              end
            end
            default: st_n = ST_CONF;
          endcase
        end
        EV_WRITE: begin
          if (st_q == ST_WCOL) begin
            if (len_q < LEN_MAX) begin
              wr_en = 1'b1;
              len_n = len_q + LEN_ONE;
            end else begin
              ovf_n = 1'b1;
            end
          end
        end
        EV_READ: begin
          case (st_q)
            ST_RSING: begin
              rd_req = 1'b1;
              st_n   = ST_DONE;
            end
            ST_RCMD: begin
              rd_req     = 1'b1;
              rd_use_cmd = !started_q;
              started_n  = 1'b1;
            end
            default: begin
              rd_bad = 1'b1;
              st_n   = ST_CONF;
            end
          endcase
        end
        EV_NACK: begin
          case (st_q)
            ST_RCMD: st_n = ST_DONE;
            ST_DONE: st_n = ST_DONE;
            default: st_n = ST_CONF;
          endcase
        end
        EV_STOP: begin
          if (st_q == ST_WCOL) begin
            act_v = 1'b1;
            if (len_q == '0) begin
              act_k = ACT_QUICK_W;
            end else if (len_q == LEN_ONE) begin
              act_k  = ACT_SEND;
              setptr = 1'b1;
            end else begin
              act_k  = ACT_BLOCK_W;
              commit = 1'b1;
            end
          end else if (st_q == ST_RSING) begin
            act_v = 1'b1;
            act_k = ACT_QUICK_R;
          end
          st_n  = ST_IDLE;
          len_n = '0;
          ovf_n = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      len_q       <= '0;
      cmd_q       <= '0;
      started_q   <= 1'b0;
      ovf_q       <= 1'b0;
      act_valid_q <= 1'b0;
      act_kind_q  <= '0;
    end else begin
      st_q        <= st_n;
      len_q       <= len_n;
      cmd_q       <= cmd_n;
      started_q   <= started_n;
      ovf_q       <= ovf_n;
      act_valid_q <= act_v;
      act_kind_q  <= act_k;
    end
  end

  for (genvar i = 0; i < BUF_BYTES; i++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        buf_q[i] <= '0;
      else if (wr_en && len_q == LEN_W'(i))
        buf_q[i] <= wdata;
    end
  end

  assign state_o  = st_q;
  assign len_o    = len_q;
  assign buf_o    = buf_q;
  assign cmd_o    = cmd_q;
  assign commit_n = len_q - LEN_ONE;

endmodule

// File: rtl/smbt_mem.sv
module smbt_mem
  import smbt_pkg::*;
#(
  parameter int MA_W      = 8,
  parameter int BUF_BYTES = 33,
  parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BUF_BYTES-1:0][7:0] buf_i,
  input  logic                      commit,
  input  logic [LEN_W-1:0]          commit_n,
  input  logic                      setptr,
  input  logic                      rd_req,
  input  logic                      rd_use_cmd,
  input  logic [7:0]                rd_cmd,
  input  logic                      rd_bad,
  output logic                      rd_valid_q,
  output logic [7:0]                rd_data_q,
  output logic [MA_W-1:0]           ptr_o
);

  localparam int DEPTH = 1 << MA_W;

  logic [7:0]      mem_q [DEPTH];
  logic [MA_W-1:0] ptr_q;
  logic [MA_W-1:0] base;
  logic [MA_W-1:0] rd_addr;

  function automatic logic [7:0] pick(input logic [BUF_BYTES-1:0][7:0] b, input int idx);
    logic [7:0] v;
    v = '0;
    for (int j = 0; j < BUF_BYTES; j++)
      if (j == idx) v = b[j];
    return v;
  endfunction

  assign base    = MA_W'(buf_i[0]);
  assign rd_addr = rd_use_cmd ? MA_W'(rd_cmd) : ptr_q;

  for (genvar a = 0; a < DEPTH; a++) begin : g_cell
    logic [MA_W-1:0] off;
    logic            hit;
    assign off = MA_W'(a) - base;
    assign hit = commit && in_window(int'(off), int'(commit_n));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[a] <= '0;
      else if (hit)
        mem_q[a] <= pick(buf_i, int'(off) + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_req || rd_bad;
      rd_data_q  <= rd_req ? mem_q[rd_addr] : 8'h00;
      if (rd_req)
        ptr_q <= rd_addr + MA_W'(1);
      else if (setptr)
        ptr_q <= base;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/smb_eeprom_target.sv
module smb_eeprom_target
  import smbt_pkg::*;
#(
  parameter int TA_W      = 7,
  parameter int MA_W      = 8,
  parameter int BUF_BYTES = 33
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TA_W-1:0] dev_addr,
  input  logic            ev_valid,
  input  logic [2:0]      ev_kind,
  input  logic [TA_W-1:0] ev_addr,
  input  logic [7:0]      ev_wdata,
  output logic            addr_ack,
  output logic            rd_valid,
  output logic [7:0]      rd_data,
  output logic            act_valid,
  output logic [2:0]      act_kind,
  output logic            confused,
  output logic            overflow
);

  localparam int LEN_W = $clog2(BUF_BYTES + 1);

  logic                      dlv;
  logic                      sel_q;
  st_e                       state;
  logic [LEN_W-1:0]          len;
  logic [BUF_BYTES-1:0][7:0] wbuf;
  logic [7:0]                cmd;
  logic                      commit;
  logic [LEN_W-1:0]          commit_n;
  logic                      setptr;
  logic                      rd_req;
  logic                      rd_use_cmd;
  logic                      rd_bad;
  logic [MA_W-1:0]           ptr;

  smbt_sel #(.TA_W(TA_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_addr (dev_addr),
    .ev_valid (ev_valid),
    .ev_kind  (ev_kind),
    .ev_addr  (ev_addr),
    .dlv      (dlv),
    .sel_q    (sel_q),
    .ack_q    (addr_ack)
  );

  smbt_fsm #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .dlv         (dlv),
    .kind        (ev_kind),
    .wdata       (ev_wdata),
    .state_o     (state),
    .len_o       (len),
    .buf_o       (wbuf),
    .cmd_o       (cmd),
    .commit      (commit),
    .commit_n    (commit_n),
    .setptr      (setptr),
    .rd_req      (rd_req),
    .rd_use_cmd  (rd_use_cmd),
    .rd_bad      (rd_bad),
    .act_valid_q (act_valid),
    .act_kind_q  (act_kind),
    .ovf_q       (overflow)
  );

  smbt_mem #(.MA_W(MA_W), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .buf_i      (wbuf),
    .commit     (commit),
    .commit_n   (commit_n),
    .setptr     (setptr),
    .rd_req     (rd_req),
    .rd_use_cmd (rd_use_cmd),
    .rd_cmd     (cmd),
    .rd_bad     (rd_bad),
    .rd_valid_q (rd_valid),
    .rd_data_q  (rd_data),
    .ptr_o      (ptr)
  );

  assign confused = (state == ST_CONF);

endmodule

// File: rtl/smbt_chk.sv
module smbt_chk
  import smbt_pkg::*;
#(
  parameter int MA_W      = 8,
  parameter int BUF_BYTES = 33,
  parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic [2:0]       ev_kind,
  input logic             dlv,
  input st_e              state,
  input logic [LEN_W-1:0] len,
  input logic             confused,
  input logic             overflow,
  input logic             commit,
  input logic             setptr,
  input logic             rd_req,
  input logic             rd_bad,
  input logic             rd_valid,
  input logic [MA_W-1:0]  ptr
);

  a_r11_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(len) <= BUF_BYTES);

  a_r12_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv && ev_kind == EV_STOP) |=> (state == ST_IDLE && !overflow && !confused));

  a_r2_restart_confuses: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv && ev_kind == EV_START_WR && state != ST_IDLE) |=> confused);

  a_r8_nack_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv && ev_kind == EV_NACK && state == ST_DONE) |=> (state == ST_DONE));

  a_r1_unselected_still: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !dlv) |=> $stable(state));

  a_r3_write_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> $stable(ptr));

  a_r9_read_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(dlv && ev_kind == EV_READ));

  a_r13_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit, setptr, rd_req, rd_bad}));

endmodule

bind smb_eeprom_target smbt_chk #(.MA_W(MA_W), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev_valid (ev_valid),
  .ev_kind  (ev_kind),
  .dlv      (dlv),
  .state    (state),
  .len      (len),
  .confused (confused),
  .overflow (overflow),
  .commit   (commit),
  .setptr   (setptr),
  .rd_req   (rd_req),
  .rd_bad   (rd_bad),
  .rd_valid (rd_valid),
  .ptr      (ptr)
);

// File: tb/tb_smb_eeprom_target.sv
module tb_smb_eeprom_target;

  localparam logic [6:0] DEV   = 7'h2A;
  localparam logic [6:0] OTHER = 7'h2B;
  localparam logic [2:0] K_SW = 3'd0, K_SR = 3'd1, K_W = 3'd2, K_R = 3'd3,
                         K_NK = 3'd4, K_SP = 3'd5, K_X = 3'd6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_kind = '0;
  logic [6:0] ev_addr = '0;
  logic [7:0] ev_wdata = '0;
  logic       addr_ack, rd_valid, act_valid, confused, overflow;
  logic [7:0] rd_data;
  logic [2:0] act_kind;

  always #10 clk = ~clk;

  smb_eeprom_target dut (
    .clk(clk), .rst_n(rst_n), .dev_addr(DEV),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr), .ev_wdata(ev_wdata),
    .addr_ack(addr_ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .act_valid(act_valid), .act_kind(act_kind),
    .confused(confused), .overflow(overflow)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] exp_rd[$];
  string      rd_tag[$];
  logic [2:0] exp_act[$];
  string      act_tag[$];

  logic [7:0] mem_m [256];
  logic [7:0] ptr_m = 8'h00;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops scoreboard items as outputs appear.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (rd_valid) begin
        if (exp_rd.size() == 0) chk("R1 R9 unexpected read byte", 32'd1, 32'd0);
        else chk(rd_tag.pop_front(), rd_data, exp_rd.pop_front());
      end
      if (act_valid) begin
        if (exp_act.size() == 0) chk("R3 unexpected transfer report", 32'd1, 32'd0);
        else chk(act_tag.pop_front(), act_kind, exp_act.pop_front());
      end
    end
  end

  task automatic push_rd(input logic [7:0] d, input string tag);
    exp_rd.push_back(d);
    rd_tag.push_back(tag);
  endtask

  task automatic push_act(input logic [2:0] k, input string tag);
    exp_act.push_back(k);
    act_tag.push_back(tag);
  endtask

  task automatic ev(input logic [2:0] k, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_addr = a; ev_wdata = d;
    @(negedge clk);
    ev_valid = 1'b0;
    if (k == K_SW || k == K_SR) chk("R1 address acknowledge", addr_ack, (a == DEV));
  endtask

  task automatic tx_send(input logic [7:0] v);
    ev(K_SW, DEV, 0); ev(K_W, DEV, v);
    push_act(3'd2, "R3 send byte");
    ev(K_SP, DEV, 0);
    ptr_m = v;
  endtask

  task automatic tx_recv(input string tag);
    ev(K_SR, DEV, 0);
    push_rd(mem_m[ptr_m], tag);
    ptr_m = ptr_m + 8'd1;
    ev(K_R, DEV, 0); ev(K_NK, DEV, 0); ev(K_SP, DEV, 0);
  endtask

  task automatic tx_block(input logic [7:0] cmd, input int n, input logic [7:0] seed, input string tag);
    ev(K_SW, DEV, 0); ev(K_W, DEV, cmd);
    for (int k = 0; k < n; k++) begin
      ev(K_W, DEV, seed + 8'(k));
      if (k < 32) mem_m[8'(cmd + 8'(k))] = seed + 8'(k);
    end
    if (n > 32) chk("R11 overflow raised", overflow, 1'b1);
    else chk("R11 overflow quiet", overflow, 1'b0);
    push_act(3'd3, tag);
    ev(K_SP, DEV, 0);
    chk("R11 overflow cleared by stop", overflow, 1'b0);
  endtask

  task automatic tx_rdata(input logic [7:0] cmd, input int n, input string tag);
    ev(K_SW, DEV, 0); ev(K_W, DEV, cmd);
    push_act(3'd4, "R6 command latch");
    ev(K_SR, DEV, 0);
    for (int k = 0; k < n; k++) begin
      push_rd(mem_m[8'(cmd + 8'(k))], tag);
      ev(K_R, DEV, 0);
    end
    ptr_m = cmd + 8'(n);
    ev(K_NK, DEV, 0); ev(K_SP, DEV, 0);
  endtask

  task automatic tx_wr_rd(input logic [7:0] cmd, input int nw, input logic [7:0] seed, input int nr);
    ev(K_SW, DEV, 0); ev(K_W, DEV, cmd);
    for (int k = 0; k < nw; k++) begin
      ev(K_W, DEV, seed + 8'(k));
      mem_m[8'(cmd + 8'(k))] = seed + 8'(k);
    end
    push_act(3'd3, "R7 write before read");
    ev(K_SR, DEV, 0);
    for (int k = 0; k < nr; k++) begin
      push_rd(mem_m[8'(cmd + 8'(k))], "R7 read after write");
      ev(K_R, DEV, 0);
    end
    ptr_m = cmd + 8'(nr);
    ev(K_NK, DEV, 0); ev(K_SP, DEV, 0);
  endtask

  task automatic summary;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14: quiet outputs and zeroed storage after reset
    chk("R14 rd_valid", rd_valid, 0);
    chk("R14 act_valid", act_valid, 0);
    chk("R14 confused", confused, 0);
    chk("R14 overflow", overflow, 0);
    chk("R14 addr_ack", addr_ack, 0);
    tx_recv("R14 zero memory at pointer 0");

    // R3 and R5 quick commands
    ev(K_SW, DEV, 0); push_act(3'd0, "R3 quick write"); ev(K_SP, DEV, 0);
    ev(K_SR, DEV, 0); push_act(3'd1, "R5 quick read"); ev(K_SP, DEV, 0);

    // R3 block write keeps pointer, then send byte sets it
    tx_block(8'h10, 4, 8'hA0, "R3 block write");
    tx_recv("R3 pointer untouched by block write");
    tx_send(8'h11);
    tx_recv("R5 receive at pointer");
    tx_recv("R5 pointer advances");

    // R4 wrap on write, R6 wrap on sequential read
    tx_block(8'hF0, 32, 8'h40, "R4 wrapping block write");
    tx_rdata(8'hFE, 4, "R6 sequential read across top");

    // R7 write then repeated-start read
    tx_wr_rd(8'h80, 3, 8'hC0, 5);

    // R11 overflow drops byte beyond 32 data bytes
    tx_block(8'h20, 34, 8'h01, "R11 block write with overflow");
    tx_rdata(8'h3E, 3, "R11 dropped byte leaves memory");

    // R1 foreign address is ignored
    tx_send(8'h11);
    ev(K_SW, OTHER, 0); ev(K_W, OTHER, 8'h10); ev(K_SP, OTHER, 0);
    ev(K_SR, OTHER, 0); ev(K_R, OTHER, 0);
    chk("R1 no read while deselected", rd_valid, 0);
    ev(K_SP, OTHER, 0);
    tx_recv("R1 pointer kept after foreign traffic");

    // R2 start-send outside idle
    ev(K_SW, DEV, 0);
    chk("R2 write-start from idle is legal", confused, 0);
    ev(K_SW, DEV, 0);
    chk("R2 write-start outside idle", confused, 1);
    ev(K_SP, DEV, 0);
    chk("R12 stop clears error", confused, 0);

    // R10 read-start with no bytes written
    ev(K_SW, DEV, 0); ev(K_SR, DEV, 0);
    chk("R10 read-start after empty write", confused, 1);
    ev(K_SP, DEV, 0);
    chk("R12 stop returns to idle", confused, 0);

    // R9 read in write-collect state
    ev(K_SW, DEV, 0);
    push_rd(8'h00, "R9 illegal read data");
    ev(K_R, DEV, 0);
    chk("R9 illegal read confuses", confused, 1);
    ev(K_SP, DEV, 0);

    // R8 NACK handling
    ev(K_SW, DEV, 0); ev(K_W, DEV, 8'h12);
    push_act(3'd4, "R6 command latch");
    ev(K_SR, DEV, 0);
    push_rd(mem_m[8'h12], "R8 read before nack");
    ev(K_R, DEV, 0);
    ptr_m = 8'h13;
    ev(K_NK, DEV, 0); ev(K_NK, DEV, 0);
    chk("R8 second nack ignored", confused, 0);
    push_rd(8'h00, "R8 read after nack");
    ev(K_R, DEV, 0);
    chk("R8 read after nack confuses", confused, 1);
    ev(K_SP, DEV, 0);
    ev(K_SW, DEV, 0); ev(K_NK, DEV, 0);
    chk("R8 nack while writing confuses", confused, 1);
    ev(K_SP, DEV, 0);

    // R13 ignored events
    ev(K_SR, DEV, 0); ev(K_W, DEV, 8'h77);
    chk("R13 byte write in read state ignored", confused, 0);
    push_rd(mem_m[ptr_m], "R13 read unaffected by stray write");
    ptr_m = ptr_m + 8'd1;
    ev(K_R, DEV, 0); ev(K_NK, DEV, 0); ev(K_SP, DEV, 0);
    ev(K_SW, DEV, 0); ev(K_X, DEV, 8'h55);
    chk("R13 unused code ignored", confused, 0);
    ev(K_W, DEV, 8'h12);
    push_act(3'd2, "R13 count unchanged by unused code");
    ev(K_SP, DEV, 0);
    ptr_m = 8'h12;
    tx_recv("R13 pointer from send byte");

    repeat (3) @(negedge clk);
    chk("R5 all read bytes seen", exp_rd.size(), 0);
    chk("R3 all transfer reports seen", exp_act.size(), 0);
    summary();
  end

endmodule